// File: doc/BRIEF.md
# Serial-Bus Register Slave with Threshold-Programming Trigger

This block is a two-wire serial-bus (I2C) slave that runs in the system clock domain. It watches oversampled copies of the bus clock and data lines and answers at the 8-bit bus address AEh for writes and AFh for reads. Each transfer carries a 16-bit word address, sent high byte first. A small byte-wide register array sits behind that address. Single-byte writes, random-address reads, sequential reads and current-address reads are supported. The slave never drives the clock line. It only pulls the data line low through an open-drain enable.

One write has a special meaning. It is only recognised while the high-voltage programming flag is asserted. The write must carry data 00h to word address 0003h. It stores its byte like any other write and also arms a threshold-programming sequence. The sequence starts at the stop condition that closes the transfer, and from then on a busy output stays high and the bus is ignored. A falling edge on the reset-pad input ends the sequence, gives a one-cycle done pulse and returns the slave to idle. A stop that closes a read puts the slave into a standby state, which the next start condition clears.

Top module: `trip_i2c_slave`

## Requirements
- R1: After reset, `sda_oe_o`, `prog_busy_o`, `prog_done_o` and `standby_o` are 0 and every register array location reads 00h. Until a start condition is seen, clocked bits are ignored and nothing is acknowledged. A start is SDA falling while SCL is high.
- R2: An address byte whose upper seven bits equal 57h is acknowledged by driving SDA low during the ninth clock. Bit 0 of that byte selects read (1) or write (0). Any other address byte gets no acknowledge, and the slave waits for the next start.
- R3: A write sends the high word-address byte, then the low word-address byte, then one data byte, and each of these is acknowledged. The data byte is stored at array index (word address modulo DEPTH).
- R4: A read, whether random or current-address, returns the byte at the address pointer, most significant bit first. The pointer advances by one after every byte sent. When the master acknowledges, the next byte follows; when it does not, the slave goes idle.
- R5: In a write, any data byte after the first is not acknowledged, is not stored and disarms the trigger.
- R6: Except on a start or a stop, `sda_oe_o` changes only in the cycle after the synchronised SCL was seen low.
- R7: A write of data 00h to word address 0003h made while `hv_prog_i` is high arms the trigger and stores 00h at index 3.
- R8: `prog_busy_o` rises only on the stop that ends an armed write. It does not rise at that write's last acknowledge.
- R9: The trigger stays unarmed in three cases: the flag is low, the data is not 00h, or the word address is not exactly 0003h (0013h is not enough, even though it maps to index 3).
- R10: A start condition that arrives before the stop disarms the trigger.
- R11: While `prog_busy_o` is high, all bus activity is ignored and `sda_oe_o` stays 0.
- R12: A falling edge of `reset_pad_i` while busy clears `prog_busy_o` and pulses `prog_done_o` for exactly one cycle. A falling edge while not busy has no effect.
- R13: `standby_o` is set by a stop that closes a read sequence, is left low by a stop after a write, and is cleared by the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire |
| hv_prog_i | input | 1 | Level flag: programming voltage present |
| reset_pad_i | input | 1 | Reset pad; a falling edge ends programming |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls SDA low |
| prog_busy_o | output | 1 | Threshold programming in progress |
| prog_done_o | output | 1 | One-cycle pulse when programming ends |
| standby_o | output | 1 | Standby after a read sequence |

## Verification
The whole 16-entry array is swept with an arithmetic data pattern. It is written through addresses whose low bytes alias, then read back three ways: by random-address reads, by one sequential burst and by a current-address read that wraps. This separates address decoding from pointer advancing. The command write is then repeated with one ingredient changed at a time (flag low, wrong data, aliased address, cut short by a repeated start). Each variant must leave busy low, while the exact command raises busy only after its stop. Unaddressed traffic, bits clocked before any start, extra data bytes, traffic during busy and reset-pad edges while idle show whether each is really ignored.

// File: rtl/trip_i2c_pkg.sv
package trip_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_BUSY
    } ctrl_st_e;

    localparam logic [15:0] CMD_WORD_ADDR = 16'h0003;
    localparam logic [7:0]  CMD_DATA      = 8'h00;
    localparam int unsigned LAST_IDX      = 4;

endpackage

// File: rtl/trip_i2c_sync.sv
module trip_i2c_sync #(
    parameter int unsigned W       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
                prev_q  <= RST_VAL[b];
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign sync_o[b] = chain_q[STAGES-1];
        assign prev_o[b] = prev_q;
    end

endmodule

// File: rtl/trip_i2c_regfile.sv
module trip_i2c_regfile #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);

    logic [7:0] mem_q [DEPTH];
    logic [7:0] mem_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we_i) begin
            mem_d[waddr_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= 8'h00;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/trip_i2c_ctrl.sv
module trip_i2c_ctrl
    import trip_i2c_pkg::*;
#(
    parameter int unsigned DEPTH  = 16,
    parameter logic [6:0]  DEV_ID = 7'h57,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_ev,
    input  logic          stop_ev,
    input  logic          hv_s,
    input  logic          rpad_fall,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          sda_oe,
    output logic          prog_busy,
    output logic          prog_done,
    output logic          standby
);

    typedef struct packed {
        ctrl_st_e    st;
        logic [3:0]  cnt;
        logic [2:0]  idx;
        logic [7:0]  sh;
        logic [7:0]  hi;
        logic [15:0] ptr;
        logic        rw;
        logic        mack;
        logic        arm;
        logic        oe;
        logic        rdseq;
        logic        stby;
        logic        done;
    } ctrl_t;

    ctrl_t q, n;
    logic [AW-1:0] idx_inc;

    assign idx_inc = q.ptr[AW-1:0] + AW'(1);
    assign rd_addr = (q.st == ST_TACK) ? idx_inc : q.ptr[AW-1:0];

    always_comb begin
        n       = q;
        n.done  = 1'b0;
        wr_en   = 1'b0;
        wr_addr = q.ptr[AW-1:0];
        wr_data = q.sh;

        if (q.st == ST_BUSY) begin
            if (rpad_fall) begin
                n.st   = ST_IDLE;
                n.done = 1'b1;
            end
        end else if (start_ev) begin
            n.st    = ST_RX;
            n.cnt   = '0;
            n.idx   = '0;
            n.arm   = 1'b0;
            n.oe    = 1'b0;
            n.rdseq = 1'b0;
            n.stby  = 1'b0;
            n.rw    = 1'b0;
        end else if (stop_ev) begin
            n.oe    = 1'b0;
            n.cnt   = '0;
            n.stby  = q.rdseq;
            n.rdseq = 1'b0;
            if (q.arm) begin
                n.st   = ST_BUSY;
                n.arm  = 1'b0;
                n.stby = 1'b0;
            end else begin
                n.st = ST_IDLE;
            end
        end else begin
            unique case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt != 4'd8) begin
                        n.sh  = {q.sh[6:0], sda_s};
                        n.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        n.cnt = '0;
                        n.st  = ST_RACK;
                        n.oe  = 1'b1;
                        unique case (q.idx)
                            3'd0: begin
                                if (q.sh[7:1] == DEV_ID) begin
                                    n.rw    = q.sh[0];
                                    n.rdseq = q.sh[0];
                                end else begin
                                    n.st = ST_IDLE;
                                    n.oe = 1'b0;
                                end
                            end
                            3'd1: n.hi  = q.sh;
                            3'd2: n.ptr = {q.hi, q.sh};
                            3'd3: begin
                                wr_en = 1'b1;
                                n.arm = hv_s && (q.ptr == CMD_WORD_ADDR)
                                        && (q.sh == CMD_DATA);
                            end
                            default: begin
                                n.st  = ST_IDLE;
                                n.oe  = 1'b0;
                                n.arm = 1'b0;
                            end
                        endcase
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        n.oe  = 1'b0;
                        n.cnt = '0;
                        if (q.rw) begin
                            n.st = ST_TX;
                            n.sh = rd_data;
                            n.oe = ~rd_data[7];
                        end else begin
                            n.st = ST_RX;
                            if (q.idx != 3'(LAST_IDX)) begin
                                n.idx = q.idx + 3'd1;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 4'd7) begin
                            n.st = ST_TACK;
                            n.oe = 1'b0;
                        end else begin
                            n.sh  = {q.sh[6:0], 1'b0};
                            n.oe  = ~q.sh[6];
                            n.cnt = q.cnt + 4'd1;
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        n.mack = ~sda_s;
                    end else if (scl_fall) begin
                        n.ptr = q.ptr + 16'd1;
                        if (q.mack) begin
                            n.st  = ST_TX;
                            n.cnt = '0;
                            n.sh  = rd_data;
                            n.oe  = ~rd_data[7];
                        end else begin
                            n.st = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= n;
        end
    end

    assign sda_oe    = q.oe;
    assign prog_busy = (q.st == ST_BUSY);
    assign prog_done = q.done;
    assign standby   = q.stby;

endmodule

// File: rtl/trip_i2c_slave.sv
module trip_i2c_slave #(
    parameter int unsigned DEPTH  = 16,
    parameter logic [6:0]  DEV_ID = 7'h57,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic hv_prog_i,
    input  logic reset_pad_i,
    output logic sda_oe_o,
    output logic prog_busy_o,
    output logic prog_done_o,
    output logic standby_o
);

    localparam int unsigned NSIG = 4;

    logic [NSIG-1:0] sig_s, sig_p;
    logic scl_s, scl_p, sda_s, sda_p, hv_s, rpad_s, rpad_p;
    logic scl_rise, scl_fall, start_ev, stop_ev, rpad_fall;

    logic [7:0]    rd_data, wr_data;
    logic [AW-1:0] rd_addr, wr_addr;
    logic          wr_en;

    trip_i2c_sync #(
        .W      (NSIG),
        .STAGES (2),
        .RST_VAL(4'b1011)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({reset_pad_i, hv_prog_i, sda_i, scl_i}),
        .sync_o (sig_s),
        .prev_o (sig_p)
    );

    assign scl_s  = sig_s[0];
    assign scl_p  = sig_p[0];
    assign sda_s  = sig_s[1];
    assign sda_p  = sig_p[1];
    assign hv_s   = sig_s[2] & sig_p[2];
    assign rpad_s = sig_s[3];
    assign rpad_p = sig_p[3];

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_ev  = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev   = scl_s & scl_p & ~sda_p & sda_s;
    assign rpad_fall = rpad_p & ~rpad_s;

    trip_i2c_ctrl #(
        .DEPTH (DEPTH),
        .DEV_ID(DEV_ID)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .hv_s     (hv_s),
        .rpad_fall(rpad_fall),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_oe   (sda_oe_o),
        .prog_busy(prog_busy_o),
        .prog_done(prog_done_o),
        .standby  (standby_o)
    );

    trip_i2c_regfile #(
        .DEPTH(DEPTH)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (wr_en),
        .waddr_i(wr_addr),
        .wdata_i(wr_data),
        .raddr_i(rd_addr),
        .rdata_o(rd_data)
    );

endmodule

// File: rtl/trip_i2c_slave_chk.sv
module trip_i2c_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_ev,
    input logic stop_ev,
    input logic rpad_fall,
    input logic sda_oe_o,
    input logic prog_busy_o,
    input logic prog_done_o,
    input logic standby_o
);

    assert_oe_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> (!$past(scl_s) || $past(start_ev) || $past(stop_ev)));

    assert_busy_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_busy_o) |-> $past(stop_ev));

    assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy_o |-> !sda_oe_o);

    assert_busy_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_busy_o) |-> ($past(rpad_fall) && prog_done_o));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done_o |=> !prog_done_o);

    assert_done_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        prog_done_o |-> ($past(prog_busy_o) && !prog_busy_o));

    assert_standby_rise_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(standby_o) |-> $past(stop_ev));

endmodule

bind trip_i2c_slave trip_i2c_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .rpad_fall  (rpad_fall),
    .sda_oe_o   (sda_oe_o),
    .prog_busy_o(prog_busy_o),
    .prog_done_o(prog_done_o),
    .standby_o  (standby_o)
);

// File: tb/trip_i2c_slave_test.sv
module trip_i2c_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam int DEPTH      = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic hv = 1'b0;
    logic rpad = 1'b1;
    logic sda_oe, busy, done, stby;
    logic sda_line;

    int n_cmp = 0;
    int n_bad = 0;
    int done_cnt = 0;
    logic [7:0] exp_mem [DEPTH];

    assign sda_line = m_sda & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trip_i2c_slave uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .hv_prog_i  (hv),
        .reset_pad_i(rpad),
        .sda_oe_o   (sda_oe),
        .prog_busy_o(busy),
        .prog_done_o(done),
        .standby_o  (stby)
    );

    always @(negedge clk) if (done) done_cnt++;

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q();
        m_scl = 1'b1; wait_q();
        m_sda = 1'b1; wait_q();
        wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wait_q();
            m_scl = 1'b1; wait_q(); wait_q();
            m_scl = 1'b0; wait_q();
        end
        m_sda = 1'b1; wait_q();
        m_scl = 1'b1; wait_q();
        ack = !sda_line;
        wait_q();
        m_scl = 1'b0; wait_q();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_q();
            m_scl = 1'b1; wait_q();
            b[i] = sda_line;
            wait_q();
            m_scl = 1'b0;
        end
        m_sda = !give_ack; wait_q();
        m_scl = 1'b1; wait_q(); wait_q();
        m_scl = 1'b0; wait_q();
        m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] hi, input logic [7:0] lo,
                            input logic [7:0] d, output logic ok);
        logic a0, a1, a2, a3;
        bus_start();
        send_byte(8'hAE, a0);
        send_byte(hi, a1);
        send_byte(lo, a2);
        send_byte(d, a3);
        bus_stop();
        ok = a0 & a1 & a2 & a3;
    endtask

    task automatic do_read(input logic [7:0] hi, input logic [7:0] lo,
                           output logic [7:0] d);
        logic a;
        bus_start();
        send_byte(8'hAE, a);
        send_byte(hi, a);
        send_byte(lo, a);
        bus_start();
        send_byte(8'hAF, a);
        recv_byte(1'b0, d);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic ok, a;
        logic [7:0] d;
        int all_ok;
        int all_match;

        for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'h00;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;

        // R1: reset state of outputs
        check("R1 reset oe", sda_oe, 0);
        check("R1 reset busy", busy, 0);
        check("R1 reset done", done, 0);
        check("R1 reset standby", stby, 0);
        do_read(8'h00, 8'h07, d);
        check("R1 reset array", d, 0);

        // R1: bits clocked with no start are ignored
        m_scl = 1'b0; wait_q();
        send_byte(8'hAE, a);
        check("R1 no start no ack", a, 0);
        bus_stop();

        // R2: wrong address not acknowledged
        bus_start();
        send_byte(8'hA0, a);
        check("R2 foreign addr nack", a, 0);
        bus_stop();
        bus_start();
        send_byte(8'hAE, a);
        check("R2 own addr ack", a, 1);
        bus_stop();

        // R3: sweep all locations with aliasing low bytes
        all_ok = 1;
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] val;
            logic [7:0] lo;
            val = 8'(i * 29 + 11);
            lo  = 8'(i + ((i % 2) * 16));
            do_write(8'(i), lo, val, ok);
            exp_mem[i] = val;
            if (!ok) all_ok = 0;
        end
        check("R3 write acks", all_ok, 1);
        check("R13 standby after write", stby, 0);

        // R4: random reads of every location
        all_match = 1;
        for (int i = 0; i < DEPTH; i++) begin
            do_read(8'h00, 8'(i), d);
            if (d != exp_mem[i]) begin
                all_match = 0;
                $display("FAIL R4: loc %0d actual %0h expected %0h", i, d, exp_mem[i]);
                n_bad++;
                n_cmp++;
            end
        end
        check("R4 random read sweep", all_match, 1);
        check("R13 standby after read", stby, 1);

        // R4: sequential read from 0 across the array
        bus_start();
        check("R13 start clears standby", stby, 0);
        send_byte(8'hAE, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'hAF, a);
        for (int i = 0; i < DEPTH; i++) begin
            recv_byte(i != DEPTH - 1, d);
            check("R4 sequential read", d, exp_mem[i]);
        end
        bus_stop();
        // R4: current address read wraps to index 0
        bus_start();
        send_byte(8'hAF, a);
        recv_byte(1'b0, d);
        bus_stop();
        check("R4 current addr wrap", d, exp_mem[0]);

        // R5: extra data byte rejected
        bus_start();
        send_byte(8'hAE, a);
        send_byte(8'h00, a);
        send_byte(8'h05, a);
        send_byte(8'h5A, a);
        check("R5 first data ack", a, 1);
        send_byte(8'hC3, a);
        check("R5 extra data nack", a, 0);
        bus_stop();
        exp_mem[5] = 8'h5A;
        do_read(8'h00, 8'h05, d);
        check("R5 first byte stored", d, exp_mem[5]);
        do_read(8'h00, 8'h06, d);
        check("R5 extra not stored", d, exp_mem[6]);

        // R9: near-miss commands
        hv = 1'b0;
        do_write(8'h00, 8'h03, 8'h00, ok);
        exp_mem[3] = 8'h00;
        repeat (10) @(posedge clk);
        #1 check("R9 flag low no busy", busy, 0);
        hv = 1'b1; wait_q();
        do_write(8'h00, 8'h03, 8'h01, ok);
        exp_mem[3] = 8'h01;
        repeat (10) @(posedge clk);
        #1 check("R9 wrong data no busy", busy, 0);
        do_write(8'h00, 8'h13, 8'h00, ok);
        exp_mem[3] = 8'h00;
        repeat (10) @(posedge clk);
        #1 check("R9 aliased addr no busy", busy, 0);
        do_write(8'h00, 8'h0B, 8'h44, ok);
        exp_mem[11] = 8'h44;

        // R10: armed write cut by repeated start
        bus_start();
        send_byte(8'hAE, a);
        send_byte(8'h00, a);
        send_byte(8'h03, a);
        send_byte(8'h00, a);
        bus_start();
        send_byte(8'hAF, a);
        recv_byte(1'b0, d);
        bus_stop();
        repeat (10) @(posedge clk);
        #1 check("R10 aborted no busy", busy, 0);
        check("R10 read after abort", d, 0);

        // R12: reset pad fall while idle has no effect
        rpad = 1'b0; wait_q(); wait_q();
        check("R12 idle pad no done", done_cnt, 0);
        check("R12 idle pad no busy", busy, 0);
        rpad = 1'b1; wait_q();

        // R7/R8: real command
        exp_mem[3] = 8'h00;
        bus_start();
        send_byte(8'hAE, a);
        send_byte(8'h00, a);
        send_byte(8'h03, a);
        send_byte(8'h00, a);
        check("R7 command ack", a, 1);
        check("R8 no busy before stop", busy, 0);
        bus_stop();
        check("R8 busy after stop", busy, 1);

        // R11: bus ignored while busy
        bus_start();
        send_byte(8'hAE, a);
        check("R11 busy nack", a, 0);
        bus_stop();
        check("R11 still busy", busy, 1);

        // R12: reset pad ends programming
        rpad = 1'b0; wait_q(); wait_q();
        check("R12 busy cleared", busy, 0);
        check("R12 one done pulse", done_cnt, 1);
        rpad = 1'b1; hv = 1'b0; wait_q();
        do_read(8'h00, 8'h03, d);
        check("R7 command stored zero", d, 0);
        do_read(8'h00, 8'h0B, d);
        check("R9 other loc kept", d, exp_mem[11]);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule